// File: doc/BRIEF.md
# Chained Highest-Index Request Encoder

This block turns a vector of request lines into the binary index of the highest-numbered active line. The block is purely combinational. It is built from a reusable eight-line encoder slice that has three extra signals. An enable input forces every slice output low. An idle flag is raised when the slice is enabled and sees no request, which separates "nothing pending" from "line 0 pending". A hit flag is raised when the slice is enabled and sees at least one request.

The top wires two slices into a sixteen-line encoder. The slice covering lines 15..8 receives the external enable. Its idle flag enables the slice covering lines 7..0, so the lower half is only encoded when the upper half is quiet. The upper slice's hit flag becomes the most significant code bit. The low three code bits are the OR of the two slice codes, which works because at most one slice is enabled at a time.

Top module: `prio_cascade`

## Requirements
- R1: With the slice enabled, its 3-bit code equals the index of the highest-numbered asserted request line (lines 0 and 2 both asserted give code 2).
- R2: With enable low, a slice drives its code, idle flag and hit flag all to 0 whatever its requests are; the same holds for the cascade's code, idle flag and hit flag.
- R3: A slice's idle flag is 1 exactly when enable is 1 and none of its request lines is asserted.
- R4: A slice's hit flag is 1 exactly when enable is 1 and at least one of its request lines is asserted.
- R5: In the cascade, code bit 3 is 1 exactly when enabled and some line among 15..8 is asserted; any asserted line in 15..8 takes priority over every line in 7..0.
- R6: In the cascade, when lines 15..8 are all low and enable is 1, code bits 2..0 give the index of the highest asserted line among 7..0; otherwise they give the upper slice's code.
- R7: The cascade idle flag is 1 exactly when enabled with all 16 lines low; the cascade hit flag is 1 exactly when enabled with any line asserted.
- R8: When enabled with no request at all, the code is 0 and only the idle flag tells this case apart from a request on line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enIn | input | 1 | Enable for the whole encoder |
| reqIn | input | 16 | Request lines, bit 15 has the highest priority |
| codeOut | output | 4 | Index of the highest asserted request |
| enOut | output | 1 | Idle flag: enabled, and no request is asserted |
| grpOut | output | 1 | Hit flag: enabled, and some request is asserted |

## Verification
The block holds no state, so any fault is visible at the ports as soon as the inputs settle, in the same cycle. A broken priority scan shows up as a wrong code for patterns that have more than one bit set. A broken enable chain shows up in one of two ways: two slices both contribute to the OR'd low bits, or the lower half is silenced while the upper half is idle. Because the idle flag and the hit flag must never both be high, and the code must be zero whenever enable is low, faults in the gating are exposed on the first stimulus that exercises them.

// File: rtl/prio_pkg.sv
package prio_pkg;
  typedef struct packed {
    logic passCode;
    logic emptyFlag;
    logic groupFlag;
  } encStrobe_t;
endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
(
  input  logic       enIn,
  input  logic       anyHit,
  output encStrobe_t strobe
);
  always_comb begin
    strobe.passCode  = enIn & anyHit;
    strobe.emptyFlag = enIn & ~anyHit;
    strobe.groupFlag = enIn & anyHit;
  end
endmodule

// File: rtl/prio_path.sv
module prio_path
  import prio_pkg::*;
#(
  parameter int WIDTH  = 8,
  localparam int CODE_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]  reqIn,
  input  encStrobe_t        strobe,
  output logic              anyHit,
  output logic [CODE_W-1:0] codeOut
);
  logic [CODE_W-1:0] rawIdx;

  always_comb begin
    rawIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (reqIn[i]) rawIdx = CODE_W'(i);
    end
  end

  assign anyHit  = |reqIn;
  assign codeOut = strobe.passCode ? rawIdx : '0;
endmodule

// File: rtl/prio_enc.sv
module prio_enc
  import prio_pkg::*;
#(
  parameter int WIDTH  = 8,
  localparam int CODE_W = $clog2(WIDTH)
) (
  input  logic              enIn,
  input  logic [WIDTH-1:0]  reqIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              enOut,
  output logic              grpOut
);
  encStrobe_t strobe;
  logic       anyHit;

  prio_ctrl i_ctrl (
    .enIn   (enIn),
    .anyHit (anyHit),
    .strobe (strobe)
  );

  prio_path #(.WIDTH(WIDTH)) i_path (
    .reqIn   (reqIn),
    .strobe  (strobe),
    .anyHit  (anyHit),
    .codeOut (codeOut)
  );

  assign enOut  = strobe.emptyFlag;
  assign grpOut = strobe.groupFlag;
endmodule

// File: rtl/prio_cascade.sv
module prio_cascade #(
  parameter int SLICE_W = 8,
  localparam int SUB_W  = $clog2(SLICE_W),
  localparam int TOT_W  = 2 * SLICE_W
) (
  input  logic             enIn,
  input  logic [TOT_W-1:0] reqIn,
  output logic [SUB_W:0]   codeOut,
  output logic             enOut,
  output logic             grpOut
);
  logic [SUB_W-1:0] sliceCode [2];
  logic [1:0]       sliceEn;
  logic [1:0]       sliceIdle;
  logic [1:0]       sliceGrp;

  // slice 1 covers the upper lines and sees the external enable;
  // slice 0 is enabled only by slice 1's idle flag
  assign sliceEn[1] = enIn;
  assign sliceEn[0] = sliceIdle[1];

  for (genvar s = 0; s < 2; s++) begin : g_slice
    prio_enc #(.WIDTH(SLICE_W)) i_enc (
      .enIn    (sliceEn[s]),
      .reqIn   (reqIn[s*SLICE_W +: SLICE_W]),
      .codeOut (sliceCode[s]),
      .enOut   (sliceIdle[s]),
      .grpOut  (sliceGrp[s])
    );
  end

  assign codeOut = {sliceGrp[1], sliceCode[1] | sliceCode[0]};
  assign enOut   = sliceIdle[0];
  assign grpOut  = sliceGrp[1] | sliceGrp[0];
endmodule

// File: rtl/prio_cascade_chk.sv
module prio_cascade_chk #(
  parameter int SLICE_W = 8,
  localparam int SUB_W  = $clog2(SLICE_W),
  localparam int TOT_W  = 2 * SLICE_W
) (
  input logic             enIn,
  input logic [TOT_W-1:0] reqIn,
  input logic [SUB_W:0]   codeOut,
  input logic             enOut,
  input logic             grpOut
);
  always_comb begin
    if (!enIn) begin
      a_r2_off_all_low: assert (codeOut == '0 && !enOut && !grpOut)
        else $error("R2 outputs active while disabled");
    end
    if (enOut) begin
      a_r3_idle_no_req: assert (reqIn == '0)
        else $error("R3 idle flag with pending request");
      a_r8_idle_code_zero: assert (codeOut == '0)
        else $error("R8 nonzero code while idle");
    end
    if (enIn) begin
      a_r7_hit_any: assert (grpOut == (reqIn != '0))
        else $error("R7 hit flag mismatch");
      a_r5_msb_upper: assert (codeOut[SUB_W] == (reqIn[TOT_W-1:SLICE_W] != '0))
        else $error("R5 code msb mismatch");
    end
    a_r4_flags_exclusive: assert (!(enOut && grpOut))
      else $error("R4 idle and hit both high");
  end
endmodule

bind prio_cascade prio_cascade_chk #(.SLICE_W(SLICE_W)) i_chk (.*);

// File: tb/test_prio_cascade.sv
`timescale 1ns/1ps
module test_prio_cascade;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enIn;
  logic [15:0] reqIn;
  logic [3:0]  codeOut;
  logic        enOut, grpOut;
  logic        bEn;
  logic [7:0]  bReq;
  logic [2:0]  bCode;
  logic        bEo, bGs;
  int          totCnt = 0;
  int          failCnt = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prio_cascade i_prio_cascade (
    .enIn(enIn), .reqIn(reqIn), .codeOut(codeOut), .enOut(enOut), .grpOut(grpOut)
  );
  prio_enc #(.WIDTH(8)) i_base (
    .enIn(bEn), .reqIn(bReq), .codeOut(bCode), .enOut(bEo), .grpOut(bGs)
  );

  // {en, req[15:0], code[3:0], idle, hit}
  localparam logic [22:0] VEC [10] = '{
    {1'b1, 16'h0000, 4'h0, 1'b1, 1'b0},
    {1'b0, 16'hFFFF, 4'h0, 1'b0, 1'b0},
    {1'b1, 16'h0001, 4'h0, 1'b0, 1'b1},
    {1'b1, 16'h8000, 4'hF, 1'b0, 1'b1},
    {1'b1, 16'h8001, 4'hF, 1'b0, 1'b1},
    {1'b1, 16'h0100, 4'h8, 1'b0, 1'b1},
    {1'b1, 16'h00FF, 4'h7, 1'b0, 1'b1},
    {1'b1, 16'h0A05, 4'hB, 1'b0, 1'b1},
    {1'b1, 16'h0080, 4'h7, 1'b0, 1'b1},
    {1'b1, 16'h0005, 4'h2, 1'b0, 1'b1}
  };

  task automatic check(string tag, int got, int exp);
    totCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int topIdx(logic [15:0] v, int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic checkCascade(logic en, logic [15:0] r, string ctx);
    int expCode;
    expCode = (en && r != 0) ? topIdx(r, 16) : 0;
    check({"R5/R6 code ", ctx}, codeOut, expCode);
    check({"R7 idle ", ctx}, enOut, (en && r == 0) ? 1 : 0);
    check({"R7 hit ", ctx}, grpOut, (en && r != 0) ? 1 : 0);
  endtask

  initial begin
    enIn = 1'b0; reqIn = '0; bEn = 1'b0; bReq = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 initial disabled state
    check("R2 reset code", codeOut, 0);
    check("R2 reset idle", enOut, 0);
    check("R2 reset hit", grpOut, 0);

    foreach (VEC[k]) begin
      @(posedge clk);
      enIn = VEC[k][22]; reqIn = VEC[k][21:6];
      @(negedge clk);
      check("R5 table code", codeOut, int'(VEC[k][5:2]));
      check("R7 table idle", enOut, int'(VEC[k][1]));
      check("R7 table hit", grpOut, int'(VEC[k][0]));
    end

    // base slice, every pattern with enable on and off: R1 R2 R3 R4 R8
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        @(posedge clk);
        bEn = e[0]; bReq = p[7:0];
        @(negedge clk);
        if (e == 0) begin
          check("R2 base code", bCode, 0);
          check("R2 base idle", bEo, 0);
          check("R2 base hit", bGs, 0);
        end else begin
          check("R1 base code", bCode, (p == 0) ? 0 : topIdx({8'h0, p[7:0]}, 8));
          check("R3 base idle", bEo, (p == 0) ? 1 : 0);
          check("R4 base hit", bGs, (p != 0) ? 1 : 0);
        end
      end
    end

    // R8: no request vs line 0 differ only by idle flag
    @(posedge clk); bEn = 1'b1; bReq = 8'h01;
    @(negedge clk);
    check("R8 line0 code", bCode, 0);
    check("R8 line0 idle", bEo, 0);

    // cascade single-hot
    for (int b = 0; b < 16; b++) begin
      @(posedge clk); enIn = 1'b1; reqIn = 16'(1) << b;
      @(negedge clk);
      checkCascade(1'b1, reqIn, "onehot");
    end

    // cascade random, enable mostly on
    for (int n = 0; n < 300; n++) begin
      logic [15:0] r;
      logic        en;
      r = 16'($urandom);
      if (n % 3 == 0) r = r & 16'h00FF;
      en = ($urandom % 5) != 0;
      @(posedge clk); enIn = en; reqIn = r;
      @(negedge clk);
      checkCascade(en, r, "random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", totCnt - failCnt, totCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      totCnt++; failCnt++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", totCnt - failCnt, totCnt);
      $finish;
    end
  end
endmodule